// File: doc/BRIEF.md
# Paired-Pointer Byte Register File

This block holds thirty-two byte-wide general registers for a small processor core. Two read ports return register contents combinationally, and one byte write port updates a single register on the rising clock edge. The six highest registers also form three 16-bit pointers, selected by code: pointer 0 uses registers 27:26, pointer 1 uses 29:28 and pointer 2 uses 31:30. In each pair the lower-numbered register holds the low byte. A separate pair write port loads a whole pointer in one cycle.

For indirect memory accesses the core presents a pointer request made of a pair select and an update mode. The block returns the effective address combinationally. On the same clock edge it writes the adjusted pointer back into its pair. Plain mode leaves the pointer unchanged. Post-increment addresses with the current value and then stores value+1. Pre-decrement computes value-1, uses that as the address and stores it. The arithmetic wraps at 16 bits. Instruction decode, the ALU and data memory are all outside this block.

Top module: `ptr_regfile`

## Requirements
- R1: An active-low asynchronous reset `rst_ni` clears all 32 registers to 0x00, without waiting for a clock edge.
- R2: Each of the two read ports returns the register at its 5-bit index combinationally. A byte write with `wr_en_i` high stores `wr_data_i` into register `wr_addr_i` at the next rising edge.
- R3: Pair select code 0 maps to registers 27:26, code 1 to 29:28 and code 2 to 31:30. The lower-numbered register holds bits 7:0. A pair write with `pair_wr_en_i` high stores `pair_wr_data_i` into both registers of the selected pair at the next rising edge.
- R4: With mode code 0 (plain), `ptr_addr_o` equals the selected pointer and the pair is left unchanged.
- R5: With mode code 1 (post-increment), `ptr_addr_o` equals the current pointer. At the next edge the pair holds that value plus 1.
- R6: With mode code 2 (pre-decrement), `ptr_addr_o` equals the pointer minus 1. At the next edge the pair holds that same value.
- R7: Pointer arithmetic wraps modulo 2^16: 0xFFFF plus 1 gives 0x0000, and 0x0000 minus 1 gives 0xFFFF.
- R8: When several writes target one register in the same cycle, the pointer write-back wins over the pair write, and the pair write wins over the byte write.
- R9: Mode code 3 behaves as plain mode. Pair select code 3 drives `ptr_addr_o` to 0x0000 and updates no register.
- R10: While `ptr_req_i` is low, no pointer write-back takes place, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_addr_i | input | 5 | Read port A register index |
| rd_a_data_o | output | 8 | Read port A data |
| rd_b_addr_i | input | 5 | Read port B register index |
| rd_b_data_o | output | 8 | Read port B data |
| wr_en_i | input | 1 | Byte write enable |
| wr_addr_i | input | 5 | Byte write register index |
| wr_data_i | input | 8 | Byte write data |
| pair_wr_en_i | input | 1 | Pair write enable |
| pair_wr_sel_i | input | 2 | Pair write select (0..2) |
| pair_wr_data_i | input | 16 | Pair write data |
| ptr_req_i | input | 1 | Pointer access request |
| ptr_sel_i | input | 2 | Pointer select (0..2, 3 = none) |
| ptr_mode_i | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 plain |
| ptr_addr_o | output | 16 | Effective address |

## Verification
The bench builds the block with its default parameters: 32 registers of 8 bits and three pairs starting at register 26. With these values every pair, and both wrap points of the 16-bit pointer, can be reached in a handful of cycles. A table of pointer operations covers every select and mode, including the 0x0000 and 0xFFFF boundaries and the reserved mode code. Directed cases then cover conflicting writes to one register, the invalid select code, requests held low, and a reset applied between clock edges.

// File: rtl/ptr_rf_pkg.sv
package ptr_rf_pkg;
  typedef enum logic [1:0] {
    PM_PLAIN    = 2'd0,
    PM_POST_INC = 2'd1,
    PM_PRE_DEC  = 2'd2,
    PM_RSVD     = 2'd3
  } ptr_mode_e;
endpackage

// File: rtl/ptr_rf_addr_unit.sv
module ptr_rf_addr_unit
  import ptr_rf_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic [PW-1:0] cur_i,
  input  ptr_mode_e     mode_i,
  output logic [PW-1:0] eff_o,
  output logic [PW-1:0] nxt_o,
  output logic          upd_o
);
  always_comb begin
    eff_o = cur_i;
    nxt_o = cur_i;
    upd_o = 1'b0;
    unique case (mode_i)
      PM_POST_INC: begin
        nxt_o = cur_i + PW'(1);
        upd_o = 1'b1;
      end
      PM_PRE_DEC: begin
        nxt_o = cur_i - PW'(1);
        eff_o = cur_i - PW'(1);
        upd_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ptr_rf_pair_merge.sv
// Write arbitration for one register that belongs to a pointer pair.
module ptr_rf_pair_merge #(
  parameter int DATA_W   = 8,
  parameter int AW       = 5,
  parameter int SEL_W    = 2,
  parameter int REG_IDX  = 26,
  parameter int PAIR_IDX = 0,
  parameter bit HI_BYTE  = 1'b0
) (
  input  logic                byte_we_i,
  input  logic [AW-1:0]       byte_addr_i,
  input  logic [DATA_W-1:0]   byte_data_i,
  input  logic                pw_en_i,
  input  logic [SEL_W-1:0]    pw_sel_i,
  input  logic [2*DATA_W-1:0] pw_data_i,
  input  logic                upd_i,
  input  logic [SEL_W-1:0]    upd_sel_i,
  input  logic [2*DATA_W-1:0] upd_val_i,
  output logic                we_o,
  output logic [DATA_W-1:0]   wd_o
);
  logic hit_byte, hit_pair, hit_upd;
  logic [DATA_W-1:0] pw_byte, upd_byte;

  assign hit_byte = byte_we_i && (byte_addr_i == AW'(REG_IDX));
  assign hit_pair = pw_en_i && (pw_sel_i == SEL_W'(PAIR_IDX));
  assign hit_upd  = upd_i && (upd_sel_i == SEL_W'(PAIR_IDX));

  if (HI_BYTE) begin : g_hi
    assign pw_byte  = pw_data_i[2*DATA_W-1:DATA_W];
    assign upd_byte = upd_val_i[2*DATA_W-1:DATA_W];
  end else begin : g_lo
    assign pw_byte  = pw_data_i[DATA_W-1:0];
    assign upd_byte = upd_val_i[DATA_W-1:0];
  end

  assign we_o = hit_byte | hit_pair | hit_upd;

  always_comb begin
    if (hit_upd)       wd_o = upd_byte;
    else if (hit_pair) wd_o = pw_byte;
    else               wd_o = byte_data_i;
  end
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import ptr_rf_pkg::*;
#(
  parameter  int NUM_REGS  = 32,
  parameter  int DATA_W    = 8,
  parameter  int PAIR_BASE = 26,
  parameter  int NUM_PAIRS = 3,
  localparam int AW        = $clog2(NUM_REGS),
  localparam int PW        = 2 * DATA_W,
  localparam int SEL_W     = $clog2(NUM_PAIRS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [AW-1:0]     rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pair_wr_en_i,
  input  logic [SEL_W-1:0]  pair_wr_sel_i,
  input  logic [PW-1:0]     pair_wr_data_i,
  input  logic              ptr_req_i,
  input  logic [SEL_W-1:0]  ptr_sel_i,
  input  logic [1:0]        ptr_mode_i,
  output logic [PW-1:0]     ptr_addr_o
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [PW-1:0]     pair_val [NUM_PAIRS];
  logic [PW-1:0]     cur_ptr, eff_ptr, nxt_ptr;
  logic              mode_upd, sel_ok, ptr_upd;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_view
    assign pair_val[p] = {regs[PAIR_BASE+2*p+1], regs[PAIR_BASE+2*p]};
  end

  always_comb begin
    cur_ptr = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (ptr_sel_i == SEL_W'(p)) cur_ptr = pair_val[p];
    end
  end

  assign sel_ok = ptr_sel_i < SEL_W'(NUM_PAIRS);

  ptr_rf_addr_unit #(.PW(PW)) i_addr_unit (
    .cur_i  (cur_ptr),
    .mode_i (ptr_mode_e'(ptr_mode_i)),
    .eff_o  (eff_ptr),
    .nxt_o  (nxt_ptr),
    .upd_o  (mode_upd)
  );

  assign ptr_upd    = ptr_req_i & sel_ok & mode_upd;
  assign ptr_addr_o = sel_ok ? eff_ptr : '0;

  assign rd_a_data_o = regs[rd_a_addr_i];
  assign rd_b_data_o = regs[rd_b_addr_i];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic              we;
    logic [DATA_W-1:0] wd;

    if (r >= PAIR_BASE && r < PAIR_BASE + 2*NUM_PAIRS) begin : g_paired
      ptr_rf_pair_merge #(
        .DATA_W   (DATA_W),
        .AW       (AW),
        .SEL_W    (SEL_W),
        .REG_IDX  (r),
        .PAIR_IDX ((r - PAIR_BASE) / 2),
        .HI_BYTE  (((r - PAIR_BASE) % 2) == 1)
      ) i_merge (
        .byte_we_i   (wr_en_i),
        .byte_addr_i (wr_addr_i),
        .byte_data_i (wr_data_i),
        .pw_en_i     (pair_wr_en_i),
        .pw_sel_i    (pair_wr_sel_i),
        .pw_data_i   (pair_wr_data_i),
        .upd_i       (ptr_upd),
        .upd_sel_i   (ptr_sel_i),
        .upd_val_i   (nxt_ptr),
        .we_o        (we),
        .wd_o        (wd)
      );
    end else begin : g_plain
      assign we = wr_en_i && (wr_addr_i == AW'(r));
      assign wd = wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs[r] <= '0;
      else if (we)  regs[r] <= wd;
    end
  end
endmodule

// File: rtl/ptr_regfile_chk.sv
module ptr_regfile_chk #(
  parameter  int NUM_REGS  = 32,
  parameter  int DATA_W    = 8,
  parameter  int PAIR_BASE = 26,
  parameter  int NUM_PAIRS = 3,
  localparam int AW        = $clog2(NUM_REGS),
  localparam int PW        = 2 * DATA_W,
  localparam int SEL_W     = $clog2(NUM_PAIRS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [AW-1:0]     wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              pair_wr_en_i,
  input logic              ptr_req_i,
  input logic [SEL_W-1:0]  ptr_sel_i,
  input logic [1:0]        ptr_mode_i,
  input logic [PW-1:0]     ptr_addr_o,
  input logic [DATA_W-1:0] regs_i [NUM_REGS]
);
  logic [SEL_W-1:0] sel_q;
  logic [PW-1:0]    cur_pair, sel_pair_q;
  logic             sel_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= ptr_sel_i;
  end

  always_comb begin
    cur_pair   = '0;
    sel_pair_q = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (ptr_sel_i == SEL_W'(p)) cur_pair   = {regs_i[PAIR_BASE+2*p+1], regs_i[PAIR_BASE+2*p]};
      if (sel_q == SEL_W'(p))     sel_pair_q = {regs_i[PAIR_BASE+2*p+1], regs_i[PAIR_BASE+2*p]};
    end
  end

  assign sel_ok = ptr_sel_i < SEL_W'(NUM_PAIRS);

  AST_POST_INC_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_req_i && sel_ok && ptr_mode_i == 2'd1 |=> sel_pair_q == PW'($past(ptr_addr_o) + PW'(1))); // R5

  AST_PRE_DEC_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ok && ptr_mode_i == 2'd2 |-> ptr_addr_o == PW'(cur_pair - PW'(1))); // R6

  AST_PRE_DEC_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_req_i && sel_ok && ptr_mode_i == 2'd2 |=> sel_pair_q == $past(ptr_addr_o)); // R6

  AST_PLAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_req_i && sel_ok && ptr_mode_i == 2'd0 && !wr_en_i && !pair_wr_en_i
    |=> sel_pair_q == $past(cur_pair)); // R4

  AST_BYTE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !(wr_addr_i >= AW'(PAIR_BASE) && (pair_wr_en_i || ptr_req_i))
    |=> regs_i[$past(wr_addr_i)] == $past(wr_data_i)); // R2

  AST_BAD_SEL_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ok |-> ptr_addr_o == '0); // R9
endmodule

bind ptr_regfile ptr_regfile_chk #(
  .NUM_REGS  (NUM_REGS),
  .DATA_W    (DATA_W),
  .PAIR_BASE (PAIR_BASE),
  .NUM_PAIRS (NUM_PAIRS)
) i_ptr_regfile_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .pair_wr_en_i (pair_wr_en_i),
  .ptr_req_i    (ptr_req_i),
  .ptr_sel_i    (ptr_sel_i),
  .ptr_mode_i   (ptr_mode_i),
  .ptr_addr_o   (ptr_addr_o),
  .regs_i       (regs)
);

// File: tb/test_ptr_regfile.sv
`timescale 1ns/1ps
module test_ptr_regfile;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0;
  logic [7:0]  rd_a_data_o, rd_b_data_o, wr_data_i = '0;
  logic        wr_en_i = 1'b0, pair_wr_en_i = 1'b0, ptr_req_i = 1'b0;
  logic [1:0]  pair_wr_sel_i = '0, ptr_sel_i = '0, ptr_mode_i = '0;
  logic [15:0] pair_wr_data_i = '0, ptr_addr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  ptr_regfile i_ptr_regfile (.*);

  // {sel[51:50], mode[49:48], start[47:32], exp_addr[31:16], exp_after[15:0]}
  localparam logic [51:0] VEC [8] = '{
    {2'd0, 2'd0, 16'h1234, 16'h1234, 16'h1234},
    {2'd0, 2'd1, 16'h1234, 16'h1234, 16'h1235},
    {2'd1, 2'd2, 16'h0100, 16'h00FF, 16'h00FF},
    {2'd2, 2'd1, 16'hFFFF, 16'hFFFF, 16'h0000},
    {2'd2, 2'd2, 16'h0000, 16'hFFFF, 16'hFFFF},
    {2'd1, 2'd1, 16'h00FF, 16'h00FF, 16'h0100},
    {2'd0, 2'd2, 16'hABCD, 16'hABCC, 16'hABCC},
    {2'd2, 2'd3, 16'h5A5A, 16'h5A5A, 16'h5A5A}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic read_pair(input logic [1:0] sel, output logic [15:0] v);
    rd_a_addr_i = 5'(26 + 2*sel);
    rd_b_addr_i = 5'(27 + 2*sel);
    #1;
    v = {rd_b_data_o, rd_a_data_o};
  endtask

  task automatic load_pair(input logic [1:0] sel, input logic [15:0] val);
    pair_wr_en_i = 1'b1; pair_wr_sel_i = sel; pair_wr_data_i = val;
    step();
    pair_wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1: reset state
    for (int r = 0; r < 32; r++) begin
      rd_a_addr_i = 5'(r); #1;
      chk("R1 reset value", 16'(rd_a_data_o), 16'h0000);
    end

    // R2: byte write and two read ports
    wr_en_i = 1'b1; wr_addr_i = 5'd5; wr_data_i = 8'hA5; step();
    wr_addr_i = 5'd31; wr_data_i = 8'h3C; step();
    wr_en_i = 1'b0;
    rd_a_addr_i = 5'd5; rd_b_addr_i = 5'd31; #1;
    chk("R2 port A", 16'(rd_a_data_o), 16'h00A5);
    chk("R2 port B", 16'(rd_b_data_o), 16'h003C);

    // R3: pair layout, low byte in lower register
    load_pair(2'd1, 16'hBEEF);
    rd_a_addr_i = 5'd28; rd_b_addr_i = 5'd29; #1;
    chk("R3 low byte reg28", 16'(rd_a_data_o), 16'h00EF);
    chk("R3 high byte reg29", 16'(rd_b_data_o), 16'h00BE);

    // R4 R5 R6 R7 R9: table of pointer operations
    for (int i = 0; i < 8; i++) begin
      load_pair(VEC[i][51:50], VEC[i][47:32]);
      ptr_req_i = 1'b1; ptr_sel_i = VEC[i][51:50]; ptr_mode_i = VEC[i][49:48];
      #1;
      chk($sformatf("R4-R7 vec%0d address", i), ptr_addr_o, VEC[i][31:16]);
      step();
      ptr_req_i = 1'b0;
      read_pair(VEC[i][51:50], v);
      chk($sformatf("R4-R7 vec%0d stored", i), v, VEC[i][15:0]);
    end

    // R8: pointer write-back beats byte write on reg 26
    load_pair(2'd0, 16'h10FF);
    ptr_req_i = 1'b1; ptr_sel_i = 2'd0; ptr_mode_i = 2'd1;
    wr_en_i = 1'b1; wr_addr_i = 5'd26; wr_data_i = 8'hEE;
    step();
    ptr_req_i = 1'b0; wr_en_i = 1'b0;
    read_pair(2'd0, v);
    chk("R8 update over byte write", v, 16'h1100);

    // R8: pair write beats byte write on reg 27
    pair_wr_en_i = 1'b1; pair_wr_sel_i = 2'd0; pair_wr_data_i = 16'hBEEF;
    wr_en_i = 1'b1; wr_addr_i = 5'd27; wr_data_i = 8'h11;
    step();
    pair_wr_en_i = 1'b0; wr_en_i = 1'b0;
    read_pair(2'd0, v);
    chk("R8 pair write over byte write", v, 16'hBEEF);

    // R8: pointer write-back beats pair write
    load_pair(2'd2, 16'h0005);
    ptr_req_i = 1'b1; ptr_sel_i = 2'd2; ptr_mode_i = 2'd1;
    pair_wr_en_i = 1'b1; pair_wr_sel_i = 2'd2; pair_wr_data_i = 16'h7777;
    step();
    ptr_req_i = 1'b0; pair_wr_en_i = 1'b0;
    read_pair(2'd2, v);
    chk("R8 update over pair write", v, 16'h0006);

    // R10: no request, no write-back
    load_pair(2'd1, 16'h4000);
    ptr_req_i = 1'b0; ptr_sel_i = 2'd1; ptr_mode_i = 2'd2;
    step(); step();
    read_pair(2'd1, v);
    chk("R10 pair unchanged without request", v, 16'h4000);

    // R9: select code 3 gives zero address and no update
    load_pair(2'd0, 16'h0123);
    ptr_req_i = 1'b1; ptr_sel_i = 2'd3; ptr_mode_i = 2'd2; #1;
    chk("R9 invalid select address", ptr_addr_o, 16'h0000);
    step();
    ptr_req_i = 1'b0;
    read_pair(2'd0, v); chk("R9 X untouched", v, 16'h0123);
    read_pair(2'd1, v); chk("R9 Y untouched", v, 16'h4000);
    read_pair(2'd2, v); chk("R9 Z untouched", v, 16'h0006);

    // R1: asynchronous reset between edges
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1;
    rd_a_addr_i = 5'd5; rd_b_addr_i = 5'd31; #1;
    chk("R1 async clear reg5", 16'(rd_a_data_o), 16'h0000);
    chk("R1 async clear reg31", 16'(rd_b_data_o), 16'h0000);
    step();
    rst_ni = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule